// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. The line idles high. A character starts with a low start bit, carries its data bits least significant first, and ends with a high stop interval. A single-cycle enable, `tick`, comes from a baud-rate divider outside the block and paces the receiver. It fires `OVS` times per bit period, so one bit lasts `OVS` ticks. Between ticks the receiver holds its state.

The line first passes through a two-flop synchronizer. While idle, the receiver looks for a low level on every tick. It accepts a start bit only when the line stays low across half a bit period. Shorter low pulses are dropped and the receiver returns to idle. After a valid start, the receiver samples once per bit period, near the centre of each data bit. It then counts out a stop interval of 1, 1.5 or 2 bit periods in ticks. At the end of that interval it presents the character with a one-cycle strobe. A frame-error flag rides on the same strobe when the first stop sample reads low. The data length and the stop length are taken from the configuration inputs at the moment a start bit is detected.

Top module: `serial_rx_core`

## Requirements
- R1: During and after synchronous active-low reset, with the line idle high, `data_valid`, `frame_err` and `data_out` are all zero.
- R2: With `cfg_seven`=0, the eight data bits are assembled least significant bit first. `data_valid` is a one-cycle pulse, and `data_out` keeps the character until the next strobe.
- R3: With `cfg_seven`=1, seven data bits are received into `data_out[6:0]`, and `data_out[7]` is 0.
- R4: After the input goes low, a start bit is accepted only if the synchronized line reads low on OVS/2+1 consecutive ticks (the detecting tick plus OVS/2 more). A shorter low pulse produces no strobe.
- R5: `cfg_stop` selects the stop interval in ticks: 0 gives OVS, 1 gives OVS+OVS/2, and 2 or 3 give 2*OVS. With `tick` high on every cycle, the strobe is seen in cycle 3 + OVS/2 + OVS*N + S after the cycle in which the input first went low. Here N is the data-bit count and S the stop tick count.
- R6: `frame_err` is 1 together with the strobe exactly when the line is low at the first stop sample, taken OVS ticks after the last data sample. The level during a second stop bit is not checked.
- R7: `cfg_seven` and `cfg_stop` are captured when a start bit is detected. Changing them during a frame does not affect that frame.
- R8: Without `tick` the receiver does not advance: a complete frame driven while `tick` is low produces no strobe. With sparse ticks, characters are still decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Oversample enable, OVS pulses per bit period |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_seven | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_stop | input | 2 | Stop length: 0 one bit, 1 one and a half, 2/3 two bits |
| data_out | output | 8 | Last received character |
| data_valid | output | 1 | One-cycle strobe for a new character |
| frame_err | output | 1 | First stop sample was low; valid with the strobe |

## Verification
With a tick on every clock, the strobe for a character falls 3 + OVS/2 + OVS*N + S cycles after the input first goes low. The count is two synchronizer cycles, one detection tick, OVS/2 qualification ticks, N full bit periods and the stop ticks. The bench records the cycle number at which the strobe is seen and compares it with this arithmetic for every timed frame. It checks data, the error flag and the pulse count only after the whole frame and some idle time have passed. Start-pulse rejection is checked at both sides of its boundary, OVS/2 and OVS/2+1 low cycles. Frames run with sparse or absent ticks are checked for their content, and for the absence of any strobe.

// File: rtl/srx_pkg.sv
// Package: shared types for the serial character receiver.
// Assumes: nothing beyond standard SystemVerilog.
package srx_pkg;

    // Receiver sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } srx_state_t;

    // Stop-length selector codes
    localparam logic [1:0] STOP_ONE      = 2'd0;
    localparam logic [1:0] STOP_ONE_HALF = 2'd1;

endpackage

// File: rtl/srx_sync.sv
// Module: srx_sync
// Purpose: brings the asynchronous serial input into the clock domain
// through a chain of flops.
// Assumes: STAGES >= 2; the reset value is the idle line level (high).
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the line level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/srx_ctrl.sv
// Module: srx_ctrl
// Purpose: sequences start qualification, data sampling and the stop
// interval, all counted in oversample ticks.
// Assumes: OVS is even and >= 4; tick is a single-cycle enable; DW >= 3.
module srx_ctrl
    import srx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic       cfg_seven,
    input  logic [1:0] cfg_stop,
    output logic       sample_en,
    output logic       done,
    output logic       ferr_now,
    output logic       seven_q
);

    localparam int CW = $clog2(2 * OVS);
    localparam int BW = $clog2(DW);
    localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);
    localparam logic [CW-1:0] ONEH_M1 = CW'(OVS + OVS / 2 - 1);
    localparam logic [CW-1:0] TWO_M1  = CW'(2 * OVS - 1);

    srx_state_t    state;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bidx;
    logic [1:0]    stop_q;
    logic          ferr_q;
    logic [CW-1:0] stop_m1;
    logic [BW-1:0] last_idx;

    // Pick the last tick index of the stop interval from the latched code
    always_comb begin
        unique case (stop_q)
            STOP_ONE:      stop_m1 = FULL_M1;
            STOP_ONE_HALF: stop_m1 = ONEH_M1;
            default:       stop_m1 = TWO_M1;
        endcase
    end

    // Index of the final data bit for the latched length
    assign last_idx = seven_q ? BW'(DW - 2) : BW'(DW - 1);

    // Main sequencer: advances only on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bidx    <= '0;
            seven_q <= 1'b0;
            stop_q  <= STOP_ONE;
            ferr_q  <= 1'b0;
        end else if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (!rx_s) begin
                        state   <= ST_START;
                        cnt     <= '0;
                        seven_q <= cfg_seven;
                        stop_q  <= cfg_stop;
                    end
                end
                ST_START: begin
                    if (rx_s) begin
                        state <= ST_IDLE;
                    end else if (cnt == HALF_M1) begin
                        state <= ST_DATA;
                        cnt   <= '0;
                        bidx  <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == FULL_M1) begin
                        cnt <= '0;
                        if (bidx == last_idx) begin
                            state <= ST_STOP;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == FULL_M1) begin
                        ferr_q <= !rx_s;
                    end
                    if (cnt == stop_m1) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Strobes toward the assembler
    assign sample_en = tick && (state == ST_DATA) && (cnt == FULL_M1);
    assign done      = tick && (state == ST_STOP) && (cnt == stop_m1);
    assign ferr_now  = (cnt == FULL_M1) ? !rx_s : ferr_q;

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(state) && $stable(cnt))); // R8

    AST_START_QUALIFIED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) == ST_START) |-> !$past(rx_s)); // R4

    AST_CFG_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(seven_q) && $stable(stop_q))); // R7

endmodule

// File: rtl/srx_assemble.sv
// Module: srx_assemble
// Purpose: shifts sampled bits in least significant first and publishes the
// character and error flag on the completion strobe.
// Assumes: sample_en and done are single-cycle and never coincide.
module srx_assemble #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_en,
    input  logic          bit_in,
    input  logic          done,
    input  logic          ferr_in,
    input  logic          seven_q,
    output logic [DW-1:0] data_out,
    output logic          data_valid,
    output logic          frame_err
);

    logic [DW-1:0] shreg;

    // Shift register: new bit enters at the top, so the first bit ends lowest
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (sample_en) begin
            shreg <= {bit_in, shreg[DW-1:1]};
        end
    end

    // Output register and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out   <= '0;
            data_valid <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            data_valid <= done;
            frame_err  <= done && ferr_in;
            if (done) begin
                data_out <= seven_q ? {1'b0, shreg[DW-1:1]} : shreg;
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid); // R2

    AST_SEVEN_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && seven_q) |-> !data_out[DW-1]); // R3

    AST_FERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> data_valid); // R6

endmodule

// File: rtl/serial_rx_core.sv
// Module: serial_rx_core
// Purpose: top of the oversampling serial receiver; wires the synchronizer,
// the tick sequencer and the character assembler.
// Assumes: OVS even and >= 4; tick from an external baud divider.
module serial_rx_core #(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_in,
    input  logic       cfg_seven,
    input  logic [1:0] cfg_stop,
    output logic [7:0] data_out,
    output logic       data_valid,
    output logic       frame_err
);

    localparam int DW = 8;

    logic rx_s;
    logic sample_en;
    logic done;
    logic ferr_now;
    logic seven_q;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_in),
        .q_sync  (rx_s)
    );

    srx_ctrl #(.OVS(OVS), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx_s      (rx_s),
        .cfg_seven (cfg_seven),
        .cfg_stop  (cfg_stop),
        .sample_en (sample_en),
        .done      (done),
        .ferr_now  (ferr_now),
        .seven_q   (seven_q)
    );

    srx_assemble #(.DW(DW)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .bit_in     (rx_s),
        .done       (done),
        .ferr_in    (ferr_now),
        .seven_q    (seven_q),
        .data_out   (data_out),
        .data_valid (data_valid),
        .frame_err  (frame_err)
    );

    // R1: the reset clears all outputs (checked at the ports by the bench)
    // R5: stop lengths are decoded inside u_ctrl

endmodule

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;

    localparam int OVS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       cfg_seven = 1'b0;
    logic [1:0] cfg_stop = 2'd0;
    logic [7:0] data_out;
    logic       data_valid;
    logic       frame_err;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int tick_div = 1;
    int tcnt = 0;
    bit tick_hold = 1'b0;
    int vcount = 0;
    int vdata = 0;
    int vferr = 0;
    int vcyc = 0;
    bit finished = 1'b0;

    serial_rx_core #(.OVS(OVS)) u_serial_rx_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rx_in      (rx_in),
        .cfg_seven  (cfg_seven),
        .cfg_stop   (cfg_stop),
        .data_out   (data_out),
        .data_valid (data_valid),
        .frame_err  (frame_err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Tick generator, updated away from the active edge
    always @(negedge clk) begin
        if (tick_hold) begin
            tick = 1'b0;
            tcnt = 0;
        end else if (tcnt >= tick_div - 1) begin
            tick = 1'b1;
            tcnt = 0;
        end else begin
            tick = 1'b0;
            tcnt = tcnt + 1;
        end
    end

    // Strobe monitor
    always @(negedge clk) begin
        if (data_valid) begin
            vcount = vcount + 1;
            vdata  = int'(data_out);
            vferr  = int'(frame_err);
            vcyc   = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int stop_ticks(input logic [1:0] sc);
        if (sc == 2'd0) return OVS;
        if (sc == 2'd1) return OVS + OVS / 2;
        return 2 * OVS;
    endfunction

    task automatic hold_line(input logic lvl, input int clocks);
        rx_in = lvl;
        repeat (clocks) @(negedge clk);
    endtask

    // Drive one frame and check the outcome
    task automatic frame_test(input logic [7:0] val, input bit seven,
                              input logic [1:0] sc, input bit s1, input bit s2,
                              input bit exp_ferr, input bit timed,
                              input string req);
        int n;
        int st;
        int c0;
        int s;
        int expd;
        n  = seven ? 7 : 8;
        st = stop_ticks(sc);
        c0 = vcount;
        cfg_seven = seven;
        cfg_stop  = sc;
        @(negedge clk);
        s = cyc;
        hold_line(1'b0, OVS * tick_div);
        for (int i = 0; i < n; i++) hold_line(val[i], OVS * tick_div);
        hold_line(s1, OVS * tick_div);
        if (st > OVS) hold_line(s2, (st - OVS) * tick_div);
        hold_line(1'b1, 2 * OVS * tick_div + 4);
        expd = seven ? int'({1'b0, val[6:0]}) : int'(val);
        chk(vcount == c0 + 1, req, "strobe count", vcount - c0, 1);
        chk(vdata == expd, req, "data", vdata, expd);
        chk(vferr == int'(exp_ferr), req, "frame_err", vferr, int'(exp_ferr));
        if (timed)
            chk(vcyc == s + 3 + OVS / 2 + OVS * n + st, req, "strobe cycle",
                vcyc - s, 3 + OVS / 2 + OVS * n + st);
        chk(int'(data_out) == expd, req, "data held", int'(data_out), expd);
    endtask

    // Low pulse followed by idle line
    task automatic pulse_test(input int len, input bit expect_char);
        int c0;
        int s;
        c0 = vcount;
        cfg_seven = 1'b0;
        cfg_stop  = 2'd0;
        @(negedge clk);
        s = cyc;
        hold_line(1'b0, len);
        hold_line(1'b1, 14 * OVS);
        if (expect_char) begin
            chk(vcount == c0 + 1, "R4", "qualified pulse strobes", vcount - c0, 1);
            chk(vdata == 255, "R4", "qualified pulse data", vdata, 255);
            chk(vcyc == s + 3 + OVS / 2 + OVS * 8 + OVS, "R4", "qualified pulse cycle",
                vcyc - s, 3 + OVS / 2 + OVS * 8 + OVS);
        end else begin
            chk(vcount == c0, "R4", "short pulse ignored", vcount - c0, 0);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(data_valid == 1'b0, "R1", "valid in reset", int'(data_valid), 0);
        chk(frame_err == 1'b0, "R1", "frame_err in reset", int'(frame_err), 0);
        chk(data_out == 8'd0, "R1", "data in reset", int'(data_out), 0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        chk(vcount == 0, "R1", "no strobe on idle line", vcount, 0);
        chk(data_out == 8'd0, "R1", "data after reset", int'(data_out), 0);

        // R2 / R5: every 8-bit value, one stop bit, exact timing
        for (int v = 0; v < 256; v++)
            frame_test(8'(v), 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R2");

        // R3 / R5: every 7-bit value, one and a half stop bits
        for (int v = 0; v < 128; v++)
            frame_test(8'(v) | 8'h80, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, "R3");

        // R5: two stop bits via both codes
        for (int v = 0; v < 16; v++) begin
            frame_test(8'(v * 17 + 3), 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
            frame_test(8'(v * 29 + 1), 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
        end

        // R4: start qualification boundary
        for (int len = 1; len <= OVS / 2; len++) pulse_test(len, 1'b0);
        pulse_test(OVS / 2 + 1, 1'b1);

        // R6: frame error cases
        frame_test(8'hA5, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, "R6");
        frame_test(8'h3C, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, "R6");
        frame_test(8'h5A, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        frame_test(8'h41, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, "R6");

        // R7: configuration changed mid-frame has no effect on that frame
        fork
            frame_test(8'hC3, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
            begin
                repeat (3 * OVS) @(negedge clk);
                cfg_seven = 1'b1;
                cfg_stop  = 2'd2;
            end
        join

        // R8: frame with no ticks produces nothing
        begin
            int c0;
            c0 = vcount;
            tick_hold = 1'b1;
            hold_line(1'b0, OVS);
            for (int i = 0; i < 8; i++) hold_line(1'(i & 1), OVS);
            hold_line(1'b1, 4 * OVS);
            chk(vcount == c0, "R8", "no strobe without tick", vcount - c0, 0);
            tick_hold = 1'b0;
            hold_line(1'b1, 2 * OVS);
            chk(vcount == c0, "R8", "no strobe after ticks resume", vcount - c0, 0);
        end

        // R8: sparse ticks
        tick_div = 3;
        frame_test(8'h96, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        frame_test(8'h0F, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        frame_test(8'h2D, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        frame_test(8'hF0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
        tick_div = 1;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule